// File: doc/BRIEF.md
# Unaligned Load Merge Unit

The unit carries out the two halves of an unaligned register load: a load-left and a load-right operation. Each half updates only part of the destination register. Software issues both halves, one after the other, against the two aligned words that an unaligned value spans. When both halves are done, the register holds the complete value.

For each operation the unit takes:

- the byte address;
- the current register contents;
- a left/right select;
- a word/doubleword size select;
- an endianness select.

The unit then issues one aligned read. It does not step through the bytes one by one. It shifts the single returned word and merges it with the register through a preserve mask. That mask is derived from the low address bits.

Only one operation is in flight at a time. The result is offered on a valid/ready output one cycle after the read data returns.

Memory lane convention: lane i of the read data is bits 8i+7..8i. Lane i holds the byte at aligned address + i when the access is little-endian. It holds the byte at aligned address + (N-1-i) when the access is big-endian. N is 4 for a word and 8 for a doubleword. For word reads, bits 63..32 of the read data are ignored.

Top module: `unaligned_load_merge`

## Requirements
- R1: The read request address is the byte address with bits 1..0 cleared for a word operation and bits 2..0 cleared for a doubleword operation. `rd_req_dword` equals the size select.
- R2: Doubleword load-left. The offset k is address bits 2..0, XORed with 7 when little-endian. The read data is shifted left by 8k bits. Register bits below bit 8k are kept.
- R3: Doubleword load-right. The offset k is address bits 2..0, XORed with 7 when big-endian. The read data is shifted right by 8k bits. Register bits at and above bit 64-8k are kept.
- R4: Word load-left applies the R2 rule within the low 32 bits, using address bits 1..0 and XOR with 3. The 32-bit result is sign-extended from bit 31 into bits 63..32.
- R5: Word load-right applies the R3 rule within the low 32 bits, using address bits 1..0 and XOR with 3. Bits 63..32 of the result are zero.
- R6: When the effective offset is 0, the new data covers the whole width and no register bit is kept. The whole register (or the whole low word) is replaced.
- R7: `out_valid` rises in the cycle after the one in which `rd_data_valid` is sampled high.
- R8: `in_ready` is low from acceptance of an operation until its result is taken with `out_valid` and `out_ready`. While `out_ready` is low, `out_valid` and `out_result` hold.
- R9: While `rd_req_ready` is low, `rd_req_valid`, `rd_req_addr` and `rd_req_dword` hold.
- R10: A synchronous active-high `rst` leaves `in_ready` high and `out_valid` and `rd_req_valid` low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit idle, operation accepted when valid |
| in_addr | input | AW | Byte address |
| in_right | input | 1 | 1 = load-right, 0 = load-left |
| in_dword | input | 1 | 1 = 64-bit, 0 = 32-bit |
| in_big_endian | input | 1 | 1 = big-endian, 0 = little-endian |
| in_reg | input | XLEN | Current destination register value |
| rd_req_valid | output | 1 | Aligned read request |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | AW | Aligned read address |
| rd_req_dword | output | 1 | Read size, 1 = doubleword |
| rd_data_valid | input | 1 | Read data returned |
| rd_data | input | XLEN | Aligned read data |
| out_valid | output | 1 | Merged result available |
| out_ready | input | 1 | Result taken |
| out_result | output | XLEN | Merged register value |

## Verification
Every combination of the following is tried, with distinct register contents each time:

- size;
- left/right;
- endianness;
- every byte offset.

These runs tell apart:

- the shift direction;
- the endian-dependent offset inversion;
- the point where kept register bytes end;
- sign versus zero fill of word results.

The offsets that replace the whole width show whether the preserve mask collapses to zero.

A randomized tail varies three things:

- request stalls;
- read latency of zero to two cycles;
- output back-pressure.

This exposes any result that is not held or any operation that is accepted while busy.

// File: rtl/unaligned_load_merge.sv
module unaligned_load_merge #(
  parameter int XLEN = 64,
  parameter int AW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [AW-1:0]   in_addr,
  input  logic            in_right,
  input  logic            in_dword,
  input  logic            in_big_endian,
  input  logic [XLEN-1:0] in_reg,
  output logic            rd_req_valid,
  input  logic            rd_req_ready,
  output logic [AW-1:0]   rd_req_addr,
  output logic            rd_req_dword,
  input  logic            rd_data_valid,
  input  logic [XLEN-1:0] rd_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result
);
  localparam int HW  = XLEN / 2;
  localparam int DB  = $clog2(XLEN / 8);
  localparam int WB  = $clog2(HW / 8);
  localparam int DSH = $clog2(XLEN);
  localparam int WSH = $clog2(HW);
  localparam logic [XLEN-1:0] D_LO_ONES = {1'b0, {(XLEN-1){1'b1}}};
  localparam logic [XLEN-1:0] D_HI_ONES = {{(XLEN-1){1'b1}}, 1'b0};
  localparam logic [HW-1:0]   W_LO_ONES = {1'b0, {(HW-1){1'b1}}};
  localparam logic [HW-1:0]   W_HI_ONES = {{(HW-1){1'b1}}, 1'b0};

  typedef enum logic [1:0] {IDLE, REQ, WAIT, DONE} st_t;
  st_t st;

  logic [AW-1:0]   a_q;
  logic            right_q, dw_q, be_q;
  logic [XLEN-1:0] reg_q, res_q;

  assign in_ready     = (st == IDLE);
  assign rd_req_valid = (st == REQ);
  assign out_valid    = (st == DONE);
  assign out_result   = res_q;
  assign rd_req_dword = dw_q;
  assign rd_req_addr  = dw_q ? {a_q[AW-1:DB], {DB{1'b0}}}
                             : {a_q[AW-1:WB], {WB{1'b0}}};

  logic            inv;
  logic [DB-1:0]   off_d;
  logic [WB-1:0]   off_w;
  logic [DSH-1:0]  sh_d;
  logic [WSH-1:0]  sh_w;
  logic [XLEN-1:0] keep_d, data_d, merged_d, merged_wx, result_n;
  logic [HW-1:0]   keep_w, data_w, merged_w;

  assign inv   = right_q ? be_q : ~be_q;
  assign off_d = a_q[DB-1:0] ^ {DB{inv}};
  assign off_w = a_q[WB-1:0] ^ {WB{inv}};
  assign sh_d  = {off_d, 3'b000};
  assign sh_w  = {off_w, 3'b000};

  assign keep_d   = right_q ? (D_HI_ONES << (sh_d ^ DSH'(XLEN-1)))
                            : (D_LO_ONES >> (sh_d ^ DSH'(XLEN-1)));
  assign data_d   = right_q ? (rd_data >> sh_d) : (rd_data << sh_d);
  assign merged_d = data_d | (reg_q & keep_d);

  assign keep_w   = right_q ? (W_HI_ONES << (sh_w ^ WSH'(HW-1)))
                            : (W_LO_ONES >> (sh_w ^ WSH'(HW-1)));
  assign data_w   = right_q ? (rd_data[HW-1:0] >> sh_w) : (rd_data[HW-1:0] << sh_w);
  assign merged_w = data_w | (reg_q[HW-1:0] & keep_w);

  assign merged_wx = right_q ? {{HW{1'b0}}, merged_w} : {{HW{merged_w[HW-1]}}, merged_w};
  assign result_n  = dw_q ? merged_d : merged_wx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= IDLE;
    end else begin
      case (st)
        IDLE: if (in_valid) st <= REQ;
        REQ:  if (rd_req_ready) st <= WAIT;
        WAIT: if (rd_data_valid) st <= DONE;
        DONE: if (out_ready) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == IDLE && in_valid) begin
      a_q     <= in_addr;
      right_q <= in_right;
      dw_q    <= in_dword;
      be_q    <= in_big_endian;
      reg_q   <= in_reg;
    end
    if (st == WAIT && rd_data_valid) res_q <= result_n;
  end
endmodule

module ulm_chk #(
  parameter int XLEN = 64,
  parameter int AW   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic            rd_req_valid,
  input logic            rd_req_ready,
  input logic [AW-1:0]   rd_req_addr,
  input logic            rd_req_dword,
  input logic            rd_data_valid,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_result
);
  // R10
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (in_ready && !rd_req_valid && !out_valid));

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (in_ready && !out_valid));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req_valid && !rd_req_ready) |=>
      (rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_dword)));

  // R7
  data_to_result_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data_valid && !in_ready && !rd_req_valid && !out_valid) |=> out_valid);
endmodule

bind unaligned_load_merge ulm_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_req_addr(rd_req_addr), .rd_req_dword(rd_req_dword),
  .rd_data_valid(rd_data_valid), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result)
);

// File: tb/sim_unaligned_load_merge.sv
`timescale 1ns/1ps
module sim_unaligned_load_merge;
  logic        clk = 1'b0, rst = 1'b1;
  logic        in_valid = 1'b0, in_ready;
  logic [31:0] in_addr = '0;
  logic        in_right = 1'b0, in_dword = 1'b0, in_big_endian = 1'b0;
  logic [63:0] in_reg = '0;
  logic        rd_req_valid, rd_req_ready = 1'b1, rd_req_dword;
  logic [31:0] rd_req_addr;
  logic        rd_data_valid = 1'b0;
  logic [63:0] rd_data = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [63:0] out_result;

  unaligned_load_merge u0 (.*);

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    rd_req_ready = (cyc % 3) != 0;
    out_ready    = (cyc % 4) != 1;
  end

  logic [7:0]  mem [0:255];
  logic [31:0] qa[$];
  logic [63:0] qr[$];
  bit          qd[$];
  string       qt[$];
  bit          cur_be = 1'b0;
  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [31:0] addr, input bit right,
                                        input bit dw, input bit be, input logic [63:0] rv);
    int n, a, base, lane;
    logic [63:0] r;
    n = dw ? 8 : 4;
    a = int'(addr[7:0]);
    base = a - (a % n);
    lane = right ? 0 : n - 1;
    r = rv;
    while (a >= base && a < base + n) begin
      r[8*lane +: 8] = mem[a];
      lane = right ? lane + 1 : lane - 1;
      a = (be ^ right) ? a + 1 : a - 1;
    end
    if (!dw) r = right ? {32'h0, r[31:0]} : {{32{r[31]}}, r[31:0]};
    return r;
  endfunction

  task automatic issue(input logic [31:0] addr, input bit right, input bit dw,
                       input bit be, input logic [63:0] rv);
    int n, k, cnt;
    string t;
    logic [63:0] e;
    n = dw ? 8 : 4;
    k = int'(addr[7:0]) % n;
    cnt = right ? (be ? k + 1 : n - k) : (be ? n - k : k + 1);
    t = (cnt == n) ? "R6" : dw ? (right ? "R3" : "R2") : (right ? "R5" : "R4");
    e = model(addr, right, dw, be, rv);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    cur_be = be;
    in_addr = addr; in_right = right; in_dword = dw; in_big_endian = be; in_reg = rv;
    in_valid = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    qa.push_back(dw ? (addr & ~32'h7) : (addr & ~32'h3));
    qd.push_back(dw);
    qr.push_back(e);
    qt.push_back(t);
  endtask

  initial begin : responder
    logic [31:0] a0;
    logic [63:0] d;
    int lat, n, base, lane;
    bit dwv;
    forever begin
      @(negedge clk);
      if (!rst && rd_req_valid) begin
        while (rd_req_valid && !rd_req_ready) begin
          a0 = rd_req_addr;
          @(negedge clk);
          chk(rd_req_valid && rd_req_addr == a0, "R9", {32'h0, rd_req_addr}, {32'h0, a0});
        end
        chk(qa.size() > 0 && rd_req_addr == qa[0] && rd_req_dword == qd[0], "R1",
            {31'h0, rd_req_dword, rd_req_addr},
            qa.size() > 0 ? {31'h0, qd[0], qa[0]} : 64'h0);
        lat = cyc % 3;
        dwv = rd_req_dword;
        base = int'(rd_req_addr[7:0]);
        n = dwv ? 8 : 4;
        d = 64'hdeadbeef_deadbeef;
        for (int i = 0; i < n; i++) begin
          lane = cur_be ? n - 1 - i : i;
          d[8*lane +: 8] = mem[base + i];
        end
        @(posedge clk);
        repeat (lat) @(posedge clk);
        #1;
        rd_data = d;
        rd_data_valid = 1'b1;
        @(posedge clk);
        #1;
        rd_data_valid = 1'b0;
        @(negedge clk);
        chk(out_valid, "R7", {63'h0, out_valid}, 64'h1);
      end
    end
  end

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (qa.size() > 0) chk(!in_ready, "R8", {63'h0, in_ready}, 64'h0);
        if (out_valid && out_ready) begin
          if (qr.size() == 0) chk(1'b0, "R8", out_result, 64'h0);
          else begin
            chk(out_result == qr[0], qt[0], out_result, qr[0]);
            void'(qa.pop_front()); void'(qd.pop_front());
            void'(qr.pop_front()); void'(qt.pop_front());
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : driver
    int it;
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(in_ready && !out_valid && !rd_req_valid, "R10",
        {61'h0, in_ready, out_valid, rd_req_valid}, 64'h4);
    @(posedge clk);
    #1 rst = 1'b0;
    it = 0;
    for (int dw = 0; dw < 2; dw++)
      for (int rt = 0; rt < 2; rt++)
        for (int be = 0; be < 2; be++)
          for (int k = 0; k < (dw ? 8 : 4); k++) begin
            issue(32'h1000_0000 + 32'((it * 8 + 16) % 192) + 32'(k), rt[0], dw[0], be[0],
                  64'hfedc_ba98_7654_3210 ^ {8{8'(it * 13)}});
            it++;
          end
    for (int j = 0; j < 40; j++)
      issue(32'($urandom % 240), 1'($urandom), 1'($urandom), 1'($urandom),
            {$urandom, $urandom});
    @(negedge clk);
    while (qa.size() > 0 || out_valid) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule